// File: doc/BRIEF.md
# Write-through store buffer

This block sits between a write-through cache and main memory. Each processor store is parked in a small queue of address/data pairs, so the processor continues without waiting for memory. The queue drains to memory in the background in arrival order, one entry on each cycle that the memory write port accepts one. The processor stalls only when every slot is occupied and nothing leaves in that cycle.

A read miss from the cache must not overtake a buffered store to the same location. A parameter picks one of two ways to guarantee this. In drain mode the read is held until the queue is empty, and new stores are held off meanwhile. In search mode every buffered address is compared with the read address. A match returns the newest buffered data for that address directly. A miss lets the read go to memory at once.

Top module: `wt_store_buf`

## Requirements
- R1: While and after reset the block reports empty_o=1, full_o=0, mem_wr_valid_o=0 and st_ready_o=1, provided st_valid_i and rd_valid_i are low.
- R2: A store is taken on a rising edge where st_valid_i and st_ready_o are both high. Up to DEPTH stores are held. When DEPTH entries are held and mem_wr_ready_i is low, st_ready_o is low and the store is not taken.
- R3: When DEPTH entries are held and mem_wr_ready_i is high, a presented store is accepted in the same cycle, and the buffer stays full.
- R4: mem_wr_valid_o is high whenever at least one entry is held. mem_wr_addr_o and mem_wr_data_o show the oldest entry. That entry leaves on an edge where mem_wr_ready_i is high. At most one entry leaves per cycle, and entries leave in the order they were accepted.
- R5: While mem_wr_valid_o is high and mem_wr_ready_i is low, mem_wr_addr_o and mem_wr_data_o hold their values into the next cycle.
- R6: With RD_MODE=RD_DRAIN (encoding 0), rd_go_o equals rd_valid_i AND an empty buffer, and rd_hit_o stays 0.
- R7: With RD_MODE=RD_DRAIN, st_ready_o is low in every cycle in which rd_valid_i is high.
- R8: With RD_MODE=RD_SEARCH (encoding 1), suppose rd_valid_i is high and one or more buffered entries have an address equal to rd_addr_i. Then rd_hit_o=1 and rd_go_o=0, and rd_data_o carries the data of the most recently accepted of those entries. A store presented in the same cycle is not searched.
- R9: With RD_MODE=RD_SEARCH, rd_valid_i with no matching entry gives rd_go_o=1 in the same cycle at any fill level. A read never lowers st_ready_o in this mode.
- R10: full_o is high exactly when DEPTH entries are held, and empty_o is high exactly when none are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| st_valid_i | input | 1 | Processor store request |
| st_addr_i | input | ADDR_W | Store address |
| st_data_i | input | DATA_W | Store data |
| st_ready_o | output | 1 | Store accepted this cycle; low means stall |
| mem_wr_valid_o | output | 1 | Memory write request (oldest entry) |
| mem_wr_addr_o | output | ADDR_W | Memory write address |
| mem_wr_data_o | output | DATA_W | Memory write data |
| mem_wr_ready_i | input | 1 | Memory accepts the write this cycle |
| rd_valid_i | input | 1 | Cache read miss pending |
| rd_addr_i | input | ADDR_W | Read miss address |
| rd_go_o | output | 1 | Read miss may be issued to memory |
| rd_hit_o | output | 1 | Read served from a buffered entry |
| rd_data_o | output | DATA_W | Forwarded data, meaningful when rd_hit_o is high |
| full_o | output | 1 | All slots occupied |
| empty_o | output | 1 | No slot occupied |

## Verification
Assertions check the following on every cycle:
- no push into a full queue without a simultaneous pop, and no pop from an empty one;
- a refused memory write holds its address and data;
- a full queue stalls a store unless an entry drains, and a store taken together with a drain leaves the queue full;
- in drain mode, no read is released while entries remain, and stores stall under a pending read;
- in search mode, hit and go are exclusive, and a non-matching read is released at once.

Only the bench scenarios can show that entries reach memory in acceptance order with the right data. They also show that the forwarded word comes from the youngest of several same-address entries when the queue has wrapped. Both modes run side by side on identical stimulus.

// File: rtl/wsb_pkg.sv
package wsb_pkg;

  typedef enum logic {
    RD_DRAIN  = 1'b0,
    RD_SEARCH = 1'b1
  } rd_mode_e;

  function automatic logic [31:0] wrap_inc(logic [31:0] p, int unsigned depth);
    return (p == 32'(depth - 1)) ? 32'd0 : p + 32'd1;
  endfunction

endpackage

// File: rtl/wsb_fifo.sv
module wsb_fifo #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] head_addr_o,
  output logic [DATA_W-1:0] head_data_o,
  output logic [ADDR_W-1:0] ent_addr_o [DEPTH],
  output logic [DATA_W-1:0] ent_data_o [DEPTH],
  output logic [PTR_W-1:0]  rd_ptr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              full_o,
  output logic              empty_o
);
  import wsb_pkg::*;

  logic [ADDR_W-1:0] ent_addr_q [DEPTH];
  logic [DATA_W-1:0] ent_data_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      ent_addr_q[wr_ptr_q] <= addr_i;
      ent_data_q[wr_ptr_q] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= PTR_W'(wrap_inc(32'(wr_ptr_q), DEPTH));
      if (pop_i)  rd_ptr_q <= PTR_W'(wrap_inc(32'(rd_ptr_q), DEPTH));
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_addr_o = ent_addr_q[rd_ptr_q];
  assign head_data_o = ent_data_q[rd_ptr_q];
  assign ent_addr_o  = ent_addr_q;
  assign ent_data_o  = ent_data_q;
  assign rd_ptr_o    = rd_ptr_q;
  assign cnt_o       = cnt_q;
  assign full_o      = (cnt_q == CNT_W'(DEPTH));
  assign empty_o     = (cnt_q == '0);

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i));
  assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  assert_empty_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !push_i) |=> empty_o);

endmodule

// File: rtl/wsb_match.sv
module wsb_match #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] ent_addr_i [DEPTH],
  input  logic [DATA_W-1:0] ent_data_i [DEPTH],
  input  logic [PTR_W-1:0]  rd_ptr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] data_o
);

  logic [PTR_W-1:0] slot;

  // Scan oldest to youngest; a later match overrides, so the youngest wins.
  always_comb begin
    hit_o  = 1'b0;
    data_o = '0;
    slot   = '0;
    for (int unsigned k = 0; k < DEPTH; k++) begin
      slot = PTR_W'((32'(rd_ptr_i) + k) % DEPTH);
      if ((CNT_W'(k) < cnt_i) && (ent_addr_i[slot] == addr_i)) begin
        hit_o  = 1'b1;
        data_o = ent_data_i[slot];
      end
    end
  end

endmodule

// File: rtl/wsb_ctrl.sv
module wsb_ctrl (
  input  logic st_valid_i,
  input  logic rd_block_i,
  input  logic full_i,
  input  logic empty_i,
  input  logic mem_ready_i,
  output logic st_ready_o,
  output logic push_o,
  output logic pop_o,
  output logic mem_valid_o
);

  assign mem_valid_o = !empty_i;
  assign pop_o       = mem_valid_o && mem_ready_i;
  // A drain in the same cycle frees the slot a full buffer needs.
  assign st_ready_o  = (!full_i || pop_o) && !rd_block_i;
  assign push_o      = st_valid_i && st_ready_o;

endmodule

// File: rtl/wt_store_buf.sv
module wt_store_buf
  import wsb_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned DEPTH   = 4,
  parameter rd_mode_e    RD_MODE = RD_DRAIN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [DATA_W-1:0] st_data_i,
  output logic              st_ready_o,
  output logic              mem_wr_valid_o,
  output logic [ADDR_W-1:0] mem_wr_addr_o,
  output logic [DATA_W-1:0] mem_wr_data_o,
  input  logic              mem_wr_ready_i,
  input  logic              rd_valid_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_go_o,
  output logic              rd_hit_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              full_o,
  output logic              empty_o
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic              push, pop, rd_block, fwd_hit;
  logic [DATA_W-1:0] fwd_data;
  logic [ADDR_W-1:0] ent_addr [DEPTH];
  logic [DATA_W-1:0] ent_data [DEPTH];
  logic [PTR_W-1:0]  rd_ptr;
  logic [CNT_W-1:0]  cnt;

  wsb_fifo #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .addr_i      (st_addr_i),
    .data_i      (st_data_i),
    .pop_i       (pop),
    .head_addr_o (mem_wr_addr_o),
    .head_data_o (mem_wr_data_o),
    .ent_addr_o  (ent_addr),
    .ent_data_o  (ent_data),
    .rd_ptr_o    (rd_ptr),
    .cnt_o       (cnt),
    .full_o      (full_o),
    .empty_o     (empty_o)
  );

  wsb_ctrl u_ctrl (
    .st_valid_i  (st_valid_i),
    .rd_block_i  (rd_block),
    .full_i      (full_o),
    .empty_i     (empty_o),
    .mem_ready_i (mem_wr_ready_i),
    .st_ready_o  (st_ready_o),
    .push_o      (push),
    .pop_o       (pop),
    .mem_valid_o (mem_wr_valid_o)
  );

  wsb_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_match (
    .addr_i     (rd_addr_i),
    .ent_addr_i (ent_addr),
    .ent_data_i (ent_data),
    .rd_ptr_i   (rd_ptr),
    .cnt_i      (cnt),
    .hit_o      (fwd_hit),
    .data_o     (fwd_data)
  );

  assign rd_data_o = fwd_hit ? fwd_data : '0;

  if (RD_MODE == RD_DRAIN) begin : g_drain
    assign rd_block = rd_valid_i;
    assign rd_go_o  = rd_valid_i && empty_o;
    assign rd_hit_o = 1'b0;

    assert_drain_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_go_o |-> empty_o);
    assert_rd_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_valid_i |-> !st_ready_o);
  end else begin : g_search
    assign rd_block = 1'b0;
    assign rd_go_o  = rd_valid_i && !fwd_hit;
    assign rd_hit_o = rd_valid_i && fwd_hit;

    assert_hit_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rd_hit_o && rd_go_o));
    assert_miss_go_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_valid_i && !rd_hit_o) |-> rd_go_o);
  end

  assert_full_stall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !mem_wr_ready_i) |-> !st_ready_o);
  assert_full_accept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && mem_wr_ready_i && st_valid_i && st_ready_o) |=> full_o);
  assert_mem_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_valid_o && !mem_wr_ready_i) |=>
      (mem_wr_valid_o && $stable(mem_wr_addr_o) && $stable(mem_wr_data_o)));
  assert_flags_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

endmodule

// File: tb/wt_store_buf_tb.sv
module wt_store_buf_tb_top;
  import wsb_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        st_valid = 1'b0, mem_ready = 1'b0, rd_valid = 1'b0;
  logic [15:0] st_addr = '0, rd_addr = '0;
  logic [31:0] st_data = '0;

  logic        d_st_ready, d_mv, d_go, d_hit, d_full, d_empty;
  logic [15:0] d_ma;
  logic [31:0] d_md, d_rd;
  logic        s_st_ready, s_mv, s_go, s_hit, s_full, s_empty;
  logic [15:0] s_ma;
  logic [31:0] s_md, s_rd;

  wt_store_buf #(.ADDR_W(16), .DATA_W(32), .DEPTH(D), .RD_MODE(RD_DRAIN)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .st_valid_i(st_valid), .st_addr_i(st_addr), .st_data_i(st_data), .st_ready_o(d_st_ready),
    .mem_wr_valid_o(d_mv), .mem_wr_addr_o(d_ma), .mem_wr_data_o(d_md), .mem_wr_ready_i(mem_ready),
    .rd_valid_i(rd_valid), .rd_addr_i(rd_addr), .rd_go_o(d_go), .rd_hit_o(d_hit), .rd_data_o(d_rd),
    .full_o(d_full), .empty_o(d_empty));

  wt_store_buf #(.ADDR_W(16), .DATA_W(32), .DEPTH(D), .RD_MODE(RD_SEARCH)) dut_srch_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .st_valid_i(st_valid), .st_addr_i(st_addr), .st_data_i(st_data), .st_ready_o(s_st_ready),
    .mem_wr_valid_o(s_mv), .mem_wr_addr_o(s_ma), .mem_wr_data_o(s_md), .mem_wr_ready_i(mem_ready),
    .rd_valid_i(rd_valid), .rd_addr_i(rd_addr), .rd_go_o(s_go), .rd_hit_o(s_hit), .rd_data_o(s_rd),
    .full_o(s_full), .empty_o(s_empty));

  logic [15:0] ma [2][D];
  logic [31:0] md [2][D];
  int cnt [2];
  int checks = 0;
  int errors = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // Drive at negedge, check settled outputs, advance the model, cross one edge.
  task automatic step(bit sv, logic [15:0] sa, logic [31:0] sd, bit mr, bit rv, logic [15:0] ra);
    st_valid = sv; st_addr = sa; st_data = sd; mem_ready = mr; rd_valid = rv; rd_addr = ra;
    #1;
    for (int m = 0; m < 2; m++) begin
      bit e_full, e_empty, e_pop, e_ready, e_push, e_hit, e_go;
      logic [31:0] e_data;
      bit a_ready, a_mv, a_go, a_hit, a_full, a_empty;
      logic [15:0] a_ma;
      logic [31:0] a_md, a_rd;
      a_ready = (m == 0) ? d_st_ready : s_st_ready;
      a_mv    = (m == 0) ? d_mv : s_mv;
      a_go    = (m == 0) ? d_go : s_go;
      a_hit   = (m == 0) ? d_hit : s_hit;
      a_full  = (m == 0) ? d_full : s_full;
      a_empty = (m == 0) ? d_empty : s_empty;
      a_ma    = (m == 0) ? d_ma : s_ma;
      a_md    = (m == 0) ? d_md : s_md;
      a_rd    = (m == 0) ? d_rd : s_rd;
      e_full  = (cnt[m] == D);
      e_empty = (cnt[m] == 0);
      e_pop   = !e_empty && mr;
      e_ready = (!e_full || e_pop) && !(m == 0 && rv);
      e_push  = sv && e_ready;
      e_hit   = 1'b0;
      e_data  = '0;
      if (m == 1)
        for (int j = 0; j < cnt[m]; j++)
          if (ma[m][j] == ra) begin e_hit = 1'b1; e_data = md[m][j]; end
      e_go  = (m == 0) ? (rv && e_empty) : (rv && !e_hit);
      e_hit = e_hit && rv;
      chk((m == 0 && rv) ? "R7" : (e_full && mr) ? "R3" : "R2", "st_ready", 64'(a_ready), 64'(e_ready));
      chk("R10", "full", 64'(a_full), 64'(e_full));
      chk("R10", "empty", 64'(a_empty), 64'(e_empty));
      chk("R4", "mem_valid", 64'(a_mv), 64'(!e_empty));
      if (!e_empty) begin
        chk("R4", "mem_addr", 64'(a_ma), 64'(ma[m][0]));
        chk("R4", "mem_data", 64'(a_md), 64'(md[m][0]));
      end
      chk((m == 0) ? "R6" : "R9", "rd_go", 64'(a_go), 64'(e_go));
      chk((m == 0) ? "R6" : "R8", "rd_hit", 64'(a_hit), 64'(e_hit));
      if (e_hit) chk("R8", "rd_data", 64'(a_rd), 64'(e_data));
      if (e_pop) begin
        for (int j = 0; j < D - 1; j++) begin ma[m][j] = ma[m][j+1]; md[m][j] = md[m][j+1]; end
        cnt[m]--;
      end
      if (e_push) begin
        ma[m][cnt[m]] = sa; md[m][cnt[m]] = sd; cnt[m]++;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drain_all();
    while (cnt[0] != 0 || cnt[1] != 0) step(1'b0, '0, '0, 1'b1, 1'b0, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    logic [15:0] held_a;
    logic [31:0] held_d;
    cnt[0] = 0; cnt[1] = 0;
    #1;
    // R1: outputs during reset
    chk("R1", "empty in reset", 64'(d_empty && s_empty), 64'(1));
    chk("R1", "full in reset", 64'(d_full || s_full), 64'(0));
    chk("R1", "mem_valid in reset", 64'(d_mv || s_mv), 64'(0));
    chk("R1", "st_ready in reset", 64'(d_st_ready && s_st_ready), 64'(1));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk("R1", "empty after reset", 64'(d_empty && s_empty), 64'(1));

    // R2: fill with memory stalled; two extra stores are refused
    step(1'b1, 16'h0100, 32'hA000_0000, 1'b0, 1'b0, '0);
    held_a = d_ma; held_d = d_md;
    for (int i = 1; i < D + 2; i++) begin
      step(1'b1, 16'h0100 + 16'(i), 32'hA000_0000 + 32'(i), 1'b0, 1'b0, '0);
      // R5: refused memory write stays put
      chk("R5", "mem addr held", 64'({d_mv, d_ma}), 64'({1'b1, held_a}));
      chk("R5", "mem data held", 64'(d_md), 64'(held_d));
    end
    // R3: store accepted on a full buffer while one entry drains
    step(1'b1, 16'h0200, 32'hB000_0000, 1'b1, 1'b0, '0);
    chk("R3", "still full", 64'(d_full && s_full), 64'(1));
    // R4: drain in order
    drain_all();

    // R6/R7/R8: drain-mode read waits; search-mode read forwards
    for (int i = 0; i < 3; i++) step(1'b1, 16'h0300 + 16'(i % 2), 32'hC000_0000 + 32'(i), 1'b0, 1'b0, '0);
    for (int i = 0; i < 3; i++) step(1'b1, 16'h0400, 32'hD000_0000 + 32'(i), 1'b0, 1'b1, 16'h0300);
    while (cnt[0] != 0) step(1'b1, 16'h0500, 32'hE000_0000, 1'b1, 1'b1, 16'h0300);
    step(1'b0, '0, '0, 1'b0, 1'b1, 16'h0300);
    drain_all();

    // R8/R9: every fill level with repeated addresses, every read address
    for (int n = 0; n <= D; n++) begin
      for (int s = 0; s < n + 1; s++) step(1'b1, 16'h0007, 32'h0, 1'b1, 1'b0, '0);
      drain_all();
      for (int k = 0; k < n; k++) step(1'b1, 16'(k % 3), 32'h1000 + 32'(n * 16 + k), 1'b0, 1'b0, '0);
      for (int a = 0; a < 4; a++) step(1'b0, '0, '0, 1'b0, 1'b1, 16'(a));
      drain_all();
    end

    // Mixed traffic with small address space
    lfsr = 32'h1D2C_3B4A;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[0], {14'd0, lfsr[3:2]}, lfsr, lfsr[5], lfsr[8] & lfsr[9], {14'd0, lfsr[11:10]});
    end
    drain_all();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule